// File: doc/BRIEF.md
# Scanline DMA Table Sequencer

This block is one channel of a DMA engine that runs once per video scanline. After an init strobe it walks a table in memory. The table is a series of entries, and each entry starts with a line-control byte. On every per-line strobe the channel decides whether to move data toward a peripheral port. It then counts the line down and fetches the next entry when the count runs out. Each data-moving line hands over `UNIT_BYTES` bytes, one at a time, through a valid/ready output.

The channel has two modes:

- In direct mode the data bytes sit inline in the table, right after their control byte.
- In indirect mode each control byte is followed by a 16-bit little-endian pointer. The data is then read from that pointer, in a separate data bank.

The register side effects are reproduced exactly. This includes a quirk when indirect mode meets a zero control byte: a malformed pointer is loaded, and the table pointer advances by only two bytes. A separate block-transfer byte count register lives beside the channel and is never touched by the sequencer.

Top module: `scanline_dma_seq`

## Requirements
- R1: An accepted init copies `tbl_base` into `tbl_ptr`, reads one byte at {`tbl_bank`,`tbl_ptr`} into `line_ctr`, and increments `tbl_ptr`. `active` goes high if that byte is nonzero.
- R2: On an accepted line strobe, data moves only if `line_ctr` was loaded since the last line decrement, or if `line_ctr` bit 7 (the repeat flag) is set. A line that moves data emits exactly `UNIT_BYTES` bytes, in address order.
- R3: In direct mode each data byte is read from {`tbl_bank`,`tbl_ptr`}, and `tbl_ptr` increments once per byte.
- R4: After the transfer decision the whole `line_ctr` byte is decremented. When bits 6:0 of the result are zero, the next control byte is read from the table and `tbl_ptr` increments.
- R5: In indirect mode every nonzero control byte is followed by a read of a pointer from the next two table bytes, low byte first, into `ind_addr`; `tbl_ptr` increments for each. Data bytes are read from {`data_bank`,`ind_addr`}, and only `ind_addr` increments for them.
- R6: In indirect mode a zero control byte puts zero into `ind_addr[7:0]` and the following table byte into `ind_addr[15:8]`. `tbl_ptr` ends two bytes past the zero. For a tail of 00 01 02 03, `ind_addr` is 0x0100 and `tbl_ptr` points at the 02.
- R7: A zero control byte clears `active`. Line strobes then have no effect (no `busy`, no reads, no output, no register change) until the next init.
- R8: `busy` is high from an accepted strobe until the sequence it started has finished. Line or init strobes that arrive while `busy` is high are ignored.
- R9: If init and a line strobe arrive in the same idle cycle, init wins and the line strobe is dropped.
- R10: `tbl_ptr` and `ind_addr` are 16 bits and wrap from 0xFFFF to 0x0000 without changing the bank.
- R11: `blk_count` changes only when `cnt_wr` is high, never through sequencer activity.
- R12: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold steady and no byte is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| init | input | 1 | Restart the table walk (one-cycle strobe) |
| line_go | input | 1 | Per-scanline transfer strobe |
| indirect | input | 1 | 1 = indirect mode; held stable while the channel runs |
| tbl_base | input | 16 | Table start address |
| tbl_bank | input | 8 | Bank of the table (and of direct data) |
| data_bank | input | 8 | Bank of indirect data |
| cnt_wr | input | 1 | Write strobe for the block byte count |
| cnt_wdata | input | 16 | Block byte count write data |
| blk_count | output | 16 | Block byte count register |
| tbl_ptr | output | 16 | Current table pointer |
| line_ctr | output | 8 | Line-control register (bit 7 repeat, 6:0 count) |
| ind_addr | output | 16 | Indirect data address |
| busy | output | 1 | Sequence in progress |
| active | output | 1 | Channel not terminated |
| mem_rd | output | 1 | Memory read request, held until acknowledged |
| mem_addr | output | 24 | Read address {bank, offset} |
| mem_rdata | input | 8 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Read completes this cycle |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_ready | input | 1 | Peripheral accepts the byte |

## Verification
Two functions can fall in the same cycle: an init and a line strobe arriving together while the channel is idle. The bench provokes this by pulsing both strobes on the same edge on a channel whose table has a count of one left. It judges the result by the absence of any output byte and by `tbl_ptr`/`line_ctr` showing a fresh restart. A second overlap, a strobe landing mid-line while `busy` is high, is provoked under output backpressure. It is judged by exactly one line's worth of bytes and a single decrement.

// File: rtl/scanline_dma_seq.sv
module scanline_dma_seq #(
  parameter int UNIT_BYTES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        line_go,
  input  logic        indirect,
  input  logic [15:0] tbl_base,
  input  logic [7:0]  tbl_bank,
  input  logic [7:0]  data_bank,
  input  logic        cnt_wr,
  input  logic [15:0] cnt_wdata,
  output logic [15:0] blk_count,
  output logic [15:0] tbl_ptr,
  output logic [7:0]  line_ctr,
  output logic [15:0] ind_addr,
  output logic        busy,
  output logic        active,
  output logic        mem_rd,
  output logic [23:0] mem_addr,
  input  logic [7:0]  mem_rdata,
  input  logic        mem_ack,
  output logic        out_valid,
  output logic [7:0]  out_data,
  input  logic        out_ready
);
  localparam int BW = (UNIT_BYTES > 1) ? $clog2(UNIT_BYTES) : 1;
  localparam logic [BW-1:0] LAST = BW'(UNIT_BYTES - 1);

  typedef enum logic [2:0] {S_IDLE, S_CTL, S_PLO, S_PHI, S_RD, S_SND, S_DEC} st_t;
  st_t st;
  logic [BW-1:0] beat;
  logic [7:0] data_q;
  logic reload;

  assign busy      = (st != S_IDLE);
  assign mem_rd    = (st == S_CTL) || (st == S_PLO) || (st == S_PHI) || (st == S_RD);
  assign mem_addr  = (st == S_RD && indirect) ? {data_bank, ind_addr} : {tbl_bank, tbl_ptr};
  assign out_valid = (st == S_SND);
  assign out_data  = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      blk_count <= '0;
      tbl_ptr <= '0;
      line_ctr <= '0;
      ind_addr <= '0;
      active <= 1'b0;
      reload <= 1'b0;
      beat <= '0;
      data_q <= '0;
    end else begin
      if (cnt_wr) blk_count <= cnt_wdata;
      case (st)
        S_IDLE: begin
          if (init) begin
            tbl_ptr <= tbl_base;
            st <= S_CTL;
          end else if (line_go && active) begin
            beat <= '0;
            st <= (reload || line_ctr[7]) ? S_RD : S_DEC;
          end
        end
        S_CTL: if (mem_ack) begin
          line_ctr <= mem_rdata;
          tbl_ptr  <= tbl_ptr + 16'd1;
          reload   <= 1'b1;
          active   <= (mem_rdata != 8'd0);
          if (!indirect) st <= S_IDLE;
          else if (mem_rdata == 8'd0) begin
            ind_addr[7:0] <= mem_rdata;
            st <= S_PHI;
          end else st <= S_PLO;
        end
        S_PLO: if (mem_ack) begin
          ind_addr[7:0] <= mem_rdata;
          tbl_ptr <= tbl_ptr + 16'd1;
          st <= S_PHI;
        end
        S_PHI: if (mem_ack) begin
          ind_addr[15:8] <= mem_rdata;
          tbl_ptr <= tbl_ptr + 16'd1;
          st <= S_IDLE;
        end
        S_RD: if (mem_ack) begin
          data_q <= mem_rdata;
          if (indirect) ind_addr <= ind_addr + 16'd1;
          else          tbl_ptr  <= tbl_ptr + 16'd1;
          st <= S_SND;
        end
        S_SND: if (out_ready) begin
          if (beat == LAST) st <= S_DEC;
          else begin
            beat <= beat + 1'b1;
            st <= S_RD;
          end
        end
        S_DEC: begin
          line_ctr <= line_ctr - 8'd1;
          reload <= 1'b0;
          st <= (line_ctr[6:0] == 7'd1) ? S_CTL : S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/scanline_dma_seq_chk.sv
module scanline_dma_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        init,
  input logic        cnt_wr,
  input logic [15:0] blk_count,
  input logic [15:0] tbl_ptr,
  input logic        busy,
  input logic        active,
  input logic        mem_rd,
  input logic        out_valid,
  input logic [7:0]  out_data,
  input logic        out_ready
);
  assert_count_untouched_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr |=> $stable(blk_count));

  assert_ptr_steps_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(init && !busy) |=> (tbl_ptr == $past(tbl_ptr)) || (tbl_ptr == $past(tbl_ptr) + 16'd1));

  assert_terminated_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !busy && !init) |=> !busy);

  assert_hold_output_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_activity_in_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd || out_valid) |-> busy);
endmodule

bind scanline_dma_seq scanline_dma_seq_chk i_chk (
  .clk(clk), .rst_n(rst_n), .init(init), .cnt_wr(cnt_wr), .blk_count(blk_count),
  .tbl_ptr(tbl_ptr), .busy(busy), .active(active), .mem_rd(mem_rd),
  .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
);

// File: tb/test_scanline_dma_seq.sv
module test_scanline_dma_seq;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, init = 1'b0, line_go = 1'b0, indirect = 1'b0;
  logic [15:0] tbl_base = '0;
  logic [7:0]  tbl_bank = '0, data_bank = '0;
  logic cnt_wr = 1'b0;
  logic [15:0] cnt_wdata = '0;
  logic [15:0] blk_count, tbl_ptr, ind_addr;
  logic [7:0]  line_ctr, out_data;
  logic busy, active, mem_rd, out_valid;
  logic [23:0] mem_addr;
  logic [7:0]  mem_rdata = '0;
  logic mem_ack = 1'b0, out_ready = 1'b1;

  int errors = 0, checks = 0, cycles = 0;
  logic [7:0] mem [int unsigned];
  logic [7:0] cap [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  scanline_dma_seq #(.UNIT_BYTES(2)) i_scanline_dma_seq (
    .clk(clk), .rst_n(rst_n), .init(init), .line_go(line_go), .indirect(indirect),
    .tbl_base(tbl_base), .tbl_bank(tbl_bank), .data_bank(data_bank),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .blk_count(blk_count),
    .tbl_ptr(tbl_ptr), .line_ctr(line_ctr), .ind_addr(ind_addr),
    .busy(busy), .active(active), .mem_rd(mem_rd), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .out_valid(out_valid), .out_data(out_data), .out_ready(out_ready)
  );

  always @(negedge clk) begin
    mem_ack = mem_rd;
    mem_rdata = mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'hEE;
  end

  always @(posedge clk) if (rst_n && out_valid && out_ready) cap.push_back(out_data);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<=20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic check_cap(input string tag, input logic [7:0] e [$]);
    check(cap.size() == e.size(), {tag, " byte count"}, cap.size(), e.size());
    foreach (e[i]) if (i < cap.size()) check(cap[i] == e[i], {tag, " byte"}, cap[i], e[i]);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic do_init();
    @(negedge clk); init = 1'b1;
    @(negedge clk); init = 1'b0;
    while (busy) @(negedge clk);
  endtask

  task automatic do_line();
    cap.delete();
    @(negedge clk); line_go = 1'b1;
    @(negedge clk); line_go = 1'b0;
    while (busy) @(negedge clk);
  endtask

  task automatic t_reset();
    check(!busy && !active && !out_valid && !mem_rd, "R8 reset idle", busy, 0);
    check(tbl_ptr == 0 && line_ctr == 0 && ind_addr == 0, "R1 reset regs", tbl_ptr, 0);
    @(negedge clk); cnt_wr = 1'b1; cnt_wdata = 16'hBEEF;
    @(negedge clk); cnt_wr = 1'b0;
    check(blk_count == 16'hBEEF, "R11 count write", blk_count, 16'hBEEF);
  endtask

  task automatic t_direct();
    logic [7:0] tbl [] = '{8'h02, 8'hA0, 8'hA1, 8'h82, 8'hC0, 8'hC1, 8'hD0, 8'hD1, 8'h00};
    foreach (tbl[i]) mem[32'h7E1000 + i] = tbl[i];
    indirect = 1'b0; tbl_base = 16'h1000; tbl_bank = 8'h7E;
    do_init();
    check(tbl_ptr == 16'h1001 && line_ctr == 8'h02 && active, "R1 init fetch", tbl_ptr, 16'h1001);
    do_line();
    check_cap("R2 R3 reload line", '{8'hA0, 8'hA1});
    check(tbl_ptr == 16'h1003 && line_ctr == 8'h01, "R3 R4 ptr/ctr line1", tbl_ptr, 16'h1003);
    do_line();
    check_cap("R2 no-repeat line", '{});
    check(tbl_ptr == 16'h1004 && line_ctr == 8'h82, "R4 reload on zero count", {tbl_ptr, line_ctr}, 24'h100482);
    do_line();
    check_cap("R2 reload repeat", '{8'hC0, 8'hC1});
    do_line();
    check_cap("R2 repeat line", '{8'hD0, 8'hD1});
    check(tbl_ptr == 16'h1009 && line_ctr == 8'h00 && !active, "R7 terminate", tbl_ptr, 16'h1009);
    do_line();
    check(!busy && cap.size() == 0 && tbl_ptr == 16'h1009 && line_ctr == 0, "R7 strobe ignored", tbl_ptr, 16'h1009);
  endtask

  task automatic t_indirect();
    logic [7:0] tbl [] = '{8'h01, 8'h34, 8'h12, 8'h00, 8'h01, 8'h02, 8'h03};
    foreach (tbl[i]) mem[32'h7F2000 + i] = tbl[i];
    mem[32'h121234] = 8'h55; mem[32'h121235] = 8'h66;
    indirect = 1'b1; tbl_base = 16'h2000; tbl_bank = 8'h7F; data_bank = 8'h12;
    do_init();
    check(ind_addr == 16'h1234 && tbl_ptr == 16'h2003, "R5 pointer load", ind_addr, 16'h1234);
    cap.delete();
    out_ready = 1'b0;
    @(negedge clk); line_go = 1'b1;
    @(negedge clk); line_go = 1'b0;
    repeat (5) @(negedge clk);
    check(out_valid && busy && out_data == 8'h55 && cap.size() == 0, "R12 backpressure hold", out_data, 8'h55);
    out_ready = 1'b1;
    while (busy) @(negedge clk);
    check_cap("R5 indirect data", '{8'h55, 8'h66});
    check(ind_addr == 16'h0100, "R6 quirk pointer", ind_addr, 16'h0100);
    check(tbl_ptr == 16'h2005 && !active, "R6 quirk table ptr", tbl_ptr, 16'h2005);
  endtask

  task automatic t_wrap();
    mem[32'h33FFFE] = 8'h01; mem[32'h33FFFF] = 8'hE0;
    mem[32'h330000] = 8'hE1; mem[32'h330001] = 8'h00;
    indirect = 1'b0; tbl_base = 16'hFFFE; tbl_bank = 8'h33;
    do_init();
    do_line();
    check_cap("R10 wrap data", '{8'hE0, 8'hE1});
    check(tbl_ptr == 16'h0002 && !active, "R10 wrap ptr", tbl_ptr, 16'h0002);
  endtask

  task automatic t_busy();
    logic [7:0] tbl [] = '{8'h03, 8'h11, 8'h22, 8'h33, 8'h44};
    foreach (tbl[i]) mem[32'h7E3000 + i] = tbl[i];
    indirect = 1'b0; tbl_base = 16'h3000; tbl_bank = 8'h7E;
    do_init();
    cap.delete();
    out_ready = 1'b0;
    @(negedge clk); line_go = 1'b1;
    @(negedge clk); line_go = 1'b0;
    repeat (3) @(negedge clk);
    line_go = 1'b1; init = 1'b1;
    @(negedge clk); line_go = 1'b0; init = 1'b0;
    out_ready = 1'b1;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    check_cap("R8 strobes while busy", '{8'h11, 8'h22});
    check(tbl_ptr == 16'h3003 && line_ctr == 8'h02 && !busy, "R8 single line effect", {tbl_ptr, line_ctr}, 24'h300302);
    do_line();
    check(cap.size() == 0 && line_ctr == 8'h01 && tbl_ptr == 16'h3003, "R2 R4 non-reload line", line_ctr, 8'h01);
  endtask

  task automatic t_collide();
    cap.delete();
    @(negedge clk); line_go = 1'b1; init = 1'b1;
    @(negedge clk); line_go = 1'b0; init = 1'b0;
    while (busy) @(negedge clk);
    check(cap.size() == 0, "R9 line dropped", cap.size(), 0);
    check(tbl_ptr == 16'h3001 && line_ctr == 8'h03, "R9 init wins", {tbl_ptr, line_ctr}, 24'h300103);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_direct();
    t_indirect();
    t_wrap();
    t_busy();
    t_collide();
    check(blk_count == 16'hBEEF, "R11 count untouched", blk_count, 16'hBEEF);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule